// File: doc/BRIEF.md
# Lap-Capable Decimal Stopwatch

This block is a four-digit decimal stopwatch driven by a 4096 Hz clock. Its count advances in hundredths of a second. Each decimal digit drives its own 7-segment output. The stopwatch is controlled by two push buttons.

The run button starts and stops timing. Elapsed time keeps adding up over any number of stop/start pairs. The lap button has a different job in each state:
- While the stopwatch runs, a lap press freezes the shown value and the count continues underneath. The next lap press lets the display follow the live count again.
- While the stopwatch is stopped, a lap press clears the count to zero.

Each button press is a short high pulse. The pulse passes through a two-stage synchroniser, and the block acts on its rising edge only once.

The hundredths rate comes from a phase accumulator. It adds a fixed step every running clock and emits one tick each time it passes the modulus. The default step of 100 against a modulus of 4096 gives exactly 100 ticks per 4096 clocks with no drift. Both values are parameters, so a small configuration can tick on every clock.

Top module: `lap_stopwatch`

## Requirements
- R1: While `rst_ni` is low, and after it is released with no key activity, all four digits show zero (segment code 1111110).
- R2: Each digit output carries the 7-bit code for its decimal value, written bit 6 down to bit 0. The codes for 0 to 9 are 1111110, 1100000, 1011011, 1110011, 1100101, 0110111, 0111111, 1100010, 1111111 and 1110111.
- R3: A key is acted on once for each low-to-high transition, however long it is held. A key sampled high at clock edge n, after being low, changes state at edge n+2.
- R4: Each run press toggles between running and stopped. The count changes only on edges where the stopwatch was already running. While stopped, the shown value holds.
- R5: After r running clock edges since the last clear, the count equals floor(STEP*r/MOD), where STEP defaults to 100 and MOD defaults to 4096.
- R6: The count is four BCD digits: d0 holds units of hundredths, and d1, d2 and d3 hold the next higher decimal places. A digit at 9 wraps to 0 and carries into the next digit, and the whole count wraps from 9999 to 0000.
- R7: A lap press while running freezes the display at the count it held just before that edge. Counting continues internally.
- R8: A second lap press while running releases the freeze, and the display follows the live count again.
- R9: A run press that stops the stopwatch also releases any freeze, so the stopped display shows the true count.
- R10: A lap press while stopped clears the count and the tick phase to zero.
- R11: When both keys rise in the same cycle, the run press acts and the lap press is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Stopwatch clock, 4096 Hz nominal |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_run_i | input | 1 | Start/stop button, active-high pulse |
| key_lap_i | input | 1 | Lap/clear button, active-high pulse |
| seg_d0_o | output | 7 | Segments of the hundredths units digit |
| seg_d1_o | output | 7 | Segments of the tens digit |
| seg_d2_o | output | 7 | Segments of the hundreds digit |
| seg_d3_o | output | 7 | Segments of the thousands digit |

## Verification
The assertions check the following on every cycle:
- every digit stays in the range 0 to 9;
- ticks occur only while running;
- the count holds while the stopwatch is stopped and no lap press arrives;
- a latched lap value stays still for as long as the freeze lasts;
- stopping releases the freeze;
- a lap press while stopped clears the count;
- simultaneous key presses start the stopwatch without clearing.

Only the bench scenarios can show the following:
- the exact long-run rate floor(100*r/4096) over thousands of cycles;
- the two-edge key latency, and that a held key acts once;
- the segment codes seen at the pins;
- the full 0000 to 9999 sweep and its wrap, run on a configuration that ticks on every clock.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int unsigned NUM_DIGITS = 4;
  localparam int unsigned DIGIT_W    = 4;
  localparam int unsigned SEG_W      = 7;

  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]   seg_t;
  typedef bcd_t [NUM_DIGITS-1:0] bcd_vec_t;

  function automatic seg_t seg_encode(input bcd_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'b1111110;
      4'd1:    s = 7'b1100000;
      4'd2:    s = 7'b1011011;
      4'd3:    s = 7'b1110011;
      4'd4:    s = 7'b1100101;
      4'd5:    s = 7'b0110111;
      4'd6:    s = 7'b0111111;
      4'd7:    s = 7'b1100010;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1110111;
      default: s = 7'b0000000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sw_key_edge.sv
module sw_key_edge #(
  parameter int unsigned N_KEYS      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_KEYS-1:0] key_i,
  output logic [N_KEYS-1:0] rise_o
);
  localparam int unsigned SH_W = SYNC_STAGES + 1;

  for (genvar k = 0; k < N_KEYS; k++) begin : g_key
    logic [SH_W-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[SH_W-2:0], key_i[k]};
    end
    // last sync stage high, previous sample low
    assign rise_o[k] = sh_q[SH_W-2] & ~sh_q[SH_W-1];
  end
endmodule

// File: rtl/sw_tick_gen.sv
module sw_tick_gen #(
  parameter int unsigned STEP = 100,
  parameter int unsigned MOD  = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned SUM_W = $clog2(MOD + STEP) + 1;

  logic [SUM_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  assign sum    = acc_q + SUM_W'(STEP);
  assign tick_o = en_i && (sum >= SUM_W'(MOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (en_i)   acc_q <= tick_o ? (sum - SUM_W'(MOD)) : sum;
  end
endmodule

// File: rtl/sw_bcd_chain.sv
module sw_bcd_chain
  import sw_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     inc_i,
  input  logic     clr_i,
  output bcd_vec_t digits_o
);
  logic [NUM_DIGITS:0] carry;
  assign carry[0] = inc_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    logic at_max;
    assign at_max     = (digits_o[i] == bcd_t'(9));
    assign carry[i+1] = carry[i] & at_max;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       digits_o[i] <= '0;
      else if (clr_i)    digits_o[i] <= '0;
      else if (carry[i]) digits_o[i] <= at_max ? '0 : digits_o[i] + bcd_t'(1);
    end
  end
endmodule

// File: rtl/sw_seg_bank.sv
module sw_seg_bank
  import sw_pkg::*;
(
  input  bcd_vec_t                      digits_i,
  output logic [NUM_DIGITS-1:0][SEG_W-1:0] segs_o
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_enc
    assign segs_o[i] = seg_encode(digits_i[i]);
  end
endmodule

// File: rtl/lap_stopwatch.sv
module lap_stopwatch
  import sw_pkg::*;
#(
  parameter int unsigned TICK_STEP = 100,
  parameter int unsigned TICK_MOD  = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_run_i,
  input  logic       key_lap_i,
  output logic [6:0] seg_d0_o,
  output logic [6:0] seg_d1_o,
  output logic [6:0] seg_d2_o,
  output logic [6:0] seg_d3_o
);
  logic [1:0] rise;
  logic       run_rise, lap_rise;
  logic       run_q, frozen_q;
  logic       tick, clr;
  bcd_vec_t   cnt, lap_q, shown;
  logic [NUM_DIGITS-1:0][SEG_W-1:0] segs;

  sw_key_edge #(.N_KEYS(2), .SYNC_STAGES(2)) u_keys (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .key_i ({key_lap_i, key_run_i}),
    .rise_o(rise)
  );
  assign run_rise = rise[0];
  assign lap_rise = rise[1];

  // run press wins over a simultaneous lap press
  assign clr = lap_rise & ~run_rise & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      frozen_q <= 1'b0;
      lap_q    <= '0;
    end else if (run_rise) begin
      run_q <= ~run_q;
      if (run_q) frozen_q <= 1'b0;
    end else if (lap_rise && run_q) begin
      frozen_q <= ~frozen_q;
      if (!frozen_q) lap_q <= cnt;
    end
  end

  sw_tick_gen #(.STEP(TICK_STEP), .MOD(TICK_MOD)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run_q),
    .clr_i (clr),
    .tick_o(tick)
  );

  sw_bcd_chain u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (tick),
    .clr_i   (clr),
    .digits_o(cnt)
  );

  assign shown = frozen_q ? lap_q : cnt;

  sw_seg_bank u_seg (
    .digits_i(shown),
    .segs_o  (segs)
  );

  assign seg_d0_o = segs[0];
  assign seg_d1_o = segs[1];
  assign seg_d2_o = segs[2];
  assign seg_d3_o = segs[3];
endmodule

// File: rtl/sw_checker.sv
module sw_checker
  import sw_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     run_q,
  input logic     frozen_q,
  input logic     run_rise,
  input logic     lap_rise,
  input logic     tick,
  input bcd_vec_t cnt,
  input bcd_vec_t lap_q
);
  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !lap_rise) |=> $stable(cnt));

  // R5
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> run_q);

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_rng
    // R6
    digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt[g] <= bcd_t'(9));
  end

  // R7
  lap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && $past(frozen_q)) |-> $stable(lap_q));

  // R9
  stop_unfreeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && run_rise) |=> (!run_q && !frozen_q));

  // R10
  stopped_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lap_rise && !run_rise && !run_q) |=> (cnt == '0));

  // R11
  both_keys_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_rise && lap_rise && !run_q) |=> (run_q && $stable(cnt)));
endmodule

bind lap_stopwatch sw_checker u_sw_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_q   (run_q),
  .frozen_q(frozen_q),
  .run_rise(run_rise),
  .lap_rise(lap_rise),
  .tick    (tick),
  .cnt     (cnt),
  .lap_q   (lap_q)
);

// File: tb/tb_lap_stopwatch.sv
module sw_ref_model #(
  parameter int unsigned STEP = 100,
  parameter int unsigned MOD  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_run,
  input  logic key_lap,
  output int   exp_val
);
  longint r;
  bit run, frz, rp, lp;
  bit kr0, kr1, kr2, kl0, kl1, kl2;
  int lapv, cur;

  function automatic int val_of(longint n);
    return int'(((longint'(STEP) * n) / longint'(MOD)) % 10000);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r = 0; run = 0; frz = 0; lapv = 0;
      kr0 = 0; kr1 = 0; kr2 = 0; kl0 = 0; kl1 = 0; kl2 = 0;
      exp_val = 0;
    end else begin
      // key seen high at edge n takes effect at edge n+2
      rp = kr1 && !kr2;
      lp = kl1 && !kl2;
      cur = val_of(r);
      kr2 = kr1; kr1 = kr0; kr0 = key_run;
      kl2 = kl1; kl1 = kl0; kl0 = key_lap;
      if (run) r = r + 1;
      if (rp) begin
        if (run) frz = 0;
        run = !run;
      end else if (lp) begin
        if (run) begin
          if (!frz) lapv = cur;
          frz = !frz;
        end else r = 0;
      end
      exp_val = frz ? lapv : val_of(r);
    end
  end
endmodule

module tb_lap_stopwatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic k_run = 1'b0, k_lap = 1'b0, f_run = 1'b0, f_lap = 1'b0;
  logic [6:0] s0, s1, s2, s3, f0, f1, f2, f3;
  int exp_main, exp_fast;
  int total = 0, bad = 0;
  bit checking = 1'b0;
  string main_req = "R1";
  string fast_req = "R6";

  always #2.5 clk = ~clk;

  lap_stopwatch dut (
    .clk_i(clk), .rst_ni(rst_n), .key_run_i(k_run), .key_lap_i(k_lap),
    .seg_d0_o(s0), .seg_d1_o(s1), .seg_d2_o(s2), .seg_d3_o(s3)
  );

  lap_stopwatch #(.TICK_STEP(2), .TICK_MOD(2)) dut_fast (
    .clk_i(clk), .rst_ni(rst_n), .key_run_i(f_run), .key_lap_i(f_lap),
    .seg_d0_o(f0), .seg_d1_o(f1), .seg_d2_o(f2), .seg_d3_o(f3)
  );

  sw_ref_model #(.STEP(100), .MOD(4096)) m_main (
    .clk(clk), .rst_n(rst_n), .key_run(k_run), .key_lap(k_lap), .exp_val(exp_main));
  sw_ref_model #(.STEP(2), .MOD(2)) m_fast (
    .clk(clk), .rst_n(rst_n), .key_run(f_run), .key_lap(f_lap), .exp_val(exp_fast));

  function automatic logic [6:0] seg_tab(int d);
    case (d)
      0: return 7'b1111110;  1: return 7'b1100000;
      2: return 7'b1011011;  3: return 7'b1110011;
      4: return 7'b1100101;  5: return 7'b0110111;
      6: return 7'b0111111;  7: return 7'b1100010;
      8: return 7'b1111111;  default: return 7'b1110111;
    endcase
  endfunction

  function automatic logic [27:0] segs_of(int v);
    return {seg_tab((v / 1000) % 10), seg_tab((v / 100) % 10),
            seg_tab((v / 10) % 10), seg_tab(v % 10)};
  endfunction

  task automatic chk(bit ok, string req, logic [27:0] act, logic [27:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s (R2 encoding) act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      chk({s3, s2, s1, s0} == segs_of(exp_main), main_req, {s3, s2, s1, s0}, segs_of(exp_main));
      chk({f3, f2, f1, f0} == segs_of(exp_fast), fast_req, {f3, f2, f1, f0}, segs_of(exp_fast));
    end
  end

  task automatic press(bit r, bit l, bit fast, int hold);
    @(negedge clk);
    if (fast) begin f_run = r; f_lap = l; end
    else begin k_run = r; k_lap = l; end
    repeat (hold) @(negedge clk);
    k_run = 0; k_lap = 0; f_run = 0; f_lap = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [27:0] held;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({s3, s2, s1, s0} == segs_of(0), "R1", {s3, s2, s1, s0}, segs_of(0));
    chk({f3, f2, f1, f0} == segs_of(0), "R1", {f3, f2, f1, f0}, segs_of(0));
    rst_n = 1'b1;
    checking = 1'b1;
    idle(10);
    chk({s3, s2, s1, s0} == segs_of(0), "R1", {s3, s2, s1, s0}, segs_of(0));

    main_req = "R5";
    press(1, 0, 0, 4);
    idle(1229);
    // ~300 ms of running: 29 or 30 hundredths
    chk((exp_main == 29 || exp_main == 30) && {s1, s0} == segs_of(exp_main)[13:0],
        "R5", {s3, s2, s1, s0}, segs_of(30));

    main_req = "R7";
    press(0, 1, 0, 4);
    idle(400);
    main_req = "R8";
    press(0, 1, 0, 4);
    idle(120);

    main_req = "R4";
    press(1, 0, 0, 4);
    idle(10);
    held = {s3, s2, s1, s0};
    idle(200);
    chk({s3, s2, s1, s0} == held, "R4", {s3, s2, s1, s0}, held);
    press(1, 0, 0, 4);
    idle(480);

    main_req = "R9";
    press(0, 1, 0, 4);
    idle(100);
    press(1, 0, 0, 4);
    idle(40);

    main_req = "R11";
    held = {s3, s2, s1, s0};
    press(1, 1, 0, 4);
    idle(2);
    chk({s3, s2, s1, s0} == held, "R11", {s3, s2, s1, s0}, held);
    idle(100);
    press(1, 0, 0, 4);
    idle(20);

    main_req = "R10";
    press(0, 1, 0, 4);
    idle(40);
    chk({s3, s2, s1, s0} == segs_of(0), "R10", {s3, s2, s1, s0}, segs_of(0));

    main_req = "R3";
    press(1, 0, 0, 200);
    idle(100);
    press(1, 0, 0, 4);
    idle(20);
    chk(exp_main > 0 && {s3, s2, s1, s0} != segs_of(0), "R3", {s3, s2, s1, s0}, segs_of(exp_main));

    // full sweep on the per-clock configuration, through the 9999 wrap
    fast_req = "R6";
    press(1, 0, 1, 2);
    idle(10100);
    press(1, 0, 1, 2);
    idle(10);
    chk(exp_fast < 200 && {f3, f2, f1, f0} == segs_of(exp_fast), "R6",
        {f3, f2, f1, f0}, segs_of(exp_fast));
    fast_req = "R10";
    press(0, 1, 1, 2);
    idle(10);
    chk({f3, f2, f1, f0} == segs_of(0), "R10", {f3, f2, f1, f0}, segs_of(0));

    checking = 1'b0;
    finish_run();
  end
endmodule